// File: doc/BRIEF.md
# Scratchpad Bank and Offset-Sign Penalty Monitor

This block watches the load/store stream that a core sends to its on-chip scratchpad and decides, for each access, whether it pays a fixed one-cycle penalty. The scratchpad holds 16 KB in four equal banks. Two things cost a cycle. The first is touching a bank other than the one the previous scratchpad access used. The second is using an immediate offset whose sign differs from the previous scratchpad access. The base register plays no part in the second rule. When either rule fires, the monitor raises a stall for exactly one cycle. No other access is taken while that stall is high.

Accesses that go to cached main memory never pay these penalties and leave the history untouched. Three free-running counters record how often each cause occurred and how many bubbles were inserted. Performance tuning can use them to see whether a loop switches banks or offset signs too often. The memory array itself lives elsewhere. This block only classifies the accesses and paces them.

Top module: `spad_penalty_mon`

## Requirements
- R1: The bank of a scratchpad access is address bits [13:12] of the scratchpad byte offset `acc_addr`, which gives four 4 KB banks in a 16 KB space.
- R2: A scratchpad access whose bank differs from the bank of the last accepted scratchpad access raises `stall` in the following cycle only, and increments `bank_cnt` by one at the same edge.
- R3: A scratchpad access whose offset sign (bit 15 of `acc_ofs`, two's complement) differs from that of the last accepted scratchpad access raises `stall` for one cycle, even when the bank is unchanged, and increments `sign_cnt` at the same edge.
- R4: When an access changes the bank and the offset sign together, only one stall cycle is inserted. `bank_cnt` and `sign_cnt` each rise by one, and `stall_cnt` rises by one.
- R5: The first scratchpad access after reset has no predecessor and never incurs a penalty.
- R6: An access with `acc_spad` low never stalls, changes no counter and leaves the remembered bank and sign unchanged.
- R7: Scratchpad accesses with the same bank and the same offset sign as their predecessor may be presented on consecutive cycles with `stall` staying low.
- R8: An access presented while `stall` is high is not accepted. It updates no history and no counter.
- R9: A zero offset counts as non-negative.
- R10: In reset `stall` is low and all three counters are zero. `stall_cnt` counts every inserted bubble, and all counters wrap at 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A load or store is presented this cycle |
| acc_spad | input | 1 | The presented access targets the scratchpad |
| acc_addr | input | 14 | Scratchpad byte offset of the access |
| acc_ofs | input | 16 | Signed immediate offset field of the instruction |
| stall | output | 1 | One-cycle unconditional bubble after a penalised access |
| bank_cnt | output | 16 | Count of bank-change penalties |
| sign_cnt | output | 16 | Count of offset-sign-change penalties |
| stall_cnt | output | 16 | Count of inserted stall bubbles |

## Verification
Every result comes from one register stage. A penalised access shows `stall` and the updated counters one clock edge after it is presented, and `stall` falls one edge after that. The bench drives on the falling edge and samples on the next falling edge, half a cycle after the edge that registers the result. After every penalty it samples one more falling edge to confirm the bubble lasts a single cycle. For an access offered during a stall, the check lands on the falling edge after the stall ends. There the counters must be unchanged, and a later access decides whether the history was disturbed.

// File: rtl/spad_pen_pkg.sv
package spad_pen_pkg;

   // Penalty kinds, also the index into the counter array
   typedef enum logic [1:0] {
      PEN_BANK  = 2'd0,
      PEN_SIGN  = 2'd1,
      PEN_STALL = 2'd2
   } pen_kind_e;

   localparam int NUM_PEN = 3;

   // Classification of one accepted access
   typedef struct packed {
      logic bubble;
      logic sign_chg;
      logic bank_chg;
   } pen_evt_t;

   function automatic logic [NUM_PEN-1:0] evt_to_vec(input pen_evt_t e);
      logic [NUM_PEN-1:0] v;
      v = '0;
      v[PEN_BANK]  = e.bank_chg;
      v[PEN_SIGN]  = e.sign_chg;
      v[PEN_STALL] = e.bubble;
      return v;
   endfunction

endpackage

// File: rtl/spad_bank_decode.sv
module spad_bank_decode #(
   parameter int ADDR_W     = 14,
   parameter int SPAD_BYTES = 16384,
   parameter int NUM_BANKS  = 4,
   localparam int BANK_BYTES = SPAD_BYTES / NUM_BANKS,
   localparam int BANK_LSB   = $clog2(BANK_BYTES),
   localparam int BANK_BITS  = $clog2(NUM_BANKS),
   localparam int BANK_W     = (BANK_BITS > 0) ? BANK_BITS : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank
);

   // Elaboration checks on the geometry
   if ((SPAD_BYTES & (SPAD_BYTES - 1)) != 0) begin : g_bad_size
      $error("spad_bank_decode: SPAD_BYTES must be a power of two");
   end
   if ((NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("spad_bank_decode: NUM_BANKS must be a power of two");
   end
   if (ADDR_W < BANK_LSB + BANK_BITS) begin : g_bad_addr
      $error("spad_bank_decode: ADDR_W too narrow for the bank field");
   end

   logic unused_addr_bits;

   if (NUM_BANKS > 1) begin : g_multi
      assign bank             = addr[BANK_LSB +: BANK_BITS];
      assign unused_addr_bits = ^{addr[BANK_LSB-1:0],
                                  addr[ADDR_W-1:BANK_LSB+BANK_BITS-1]};
   end else begin : g_single
      // A single bank can never change
      assign bank             = '0;
      assign unused_addr_bits = ^addr;
   end

endmodule

// File: rtl/spad_pen_tracker.sv
module spad_pen_tracker
   import spad_pen_pkg::*;
#(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [BANK_W-1:0] bank,
   input  logic              neg,
   output pen_evt_t          evt,
   output logic              stall_q
);

   logic              have_prev;
   logic [BANK_W-1:0] prev_bank;
   logic              prev_neg;

   logic bank_diff;
   logic sign_diff;

   always_comb begin
      bank_diff    = (bank != prev_bank);
      sign_diff    = (neg != prev_neg);
      evt          = '0;
      evt.bank_chg = accept && have_prev && bank_diff;
      evt.sign_chg = accept && have_prev && sign_diff;
      evt.bubble   = evt.bank_chg || evt.sign_chg;
   end

   // History of the last accepted scratchpad access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_bank <= '0;
         prev_neg  <= 1'b0;
      end else if (accept) begin
         have_prev <= 1'b1;
         prev_bank <= bank;
         prev_neg  <= neg;
      end
   end

   // One bubble per penalised access, merged when both causes coincide
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
      end else begin
         stall_q <= evt.bubble;
      end
   end

endmodule

// File: rtl/spad_pen_counter.sv
module spad_pen_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   if (CNT_W < 1) begin : g_bad_w
      $error("spad_pen_counter: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc) begin
         count <= count + CNT_W'(1);
      end
   end

endmodule

// File: rtl/spad_penalty_mon.sv
module spad_penalty_mon
   import spad_pen_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int OFS_W      = 16,
   parameter int SPAD_BYTES = 16384,
   parameter int NUM_BANKS  = 4,
   parameter int CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_spad,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [OFS_W-1:0]  acc_ofs,
   output logic              stall,
   output logic [CNT_W-1:0]  bank_cnt,
   output logic [CNT_W-1:0]  sign_cnt,
   output logic [CNT_W-1:0]  stall_cnt
);

   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam int BANK_W    = (BANK_BITS > 0) ? BANK_BITS : 1;

   if (OFS_W < 2) begin : g_bad_ofs
      $error("spad_penalty_mon: OFS_W must be at least 2");
   end

   logic              accept;
   logic [BANK_W-1:0] bank;
   logic              ofs_neg;
   pen_evt_t          evt;
   logic [NUM_PEN-1:0] evt_vec;
   logic [CNT_W-1:0]  cnt_arr [NUM_PEN];
   logic              unused_ofs_bits;

   // No access is taken while a bubble is in progress
   assign accept          = acc_valid && acc_spad && !stall;
   assign ofs_neg         = acc_ofs[OFS_W-1];
   assign unused_ofs_bits = ^acc_ofs[OFS_W-2:0];

   spad_bank_decode #(
      .ADDR_W     (ADDR_W),
      .SPAD_BYTES (SPAD_BYTES),
      .NUM_BANKS  (NUM_BANKS)
   ) u_bank (
      .addr (acc_addr),
      .bank (bank)
   );

   spad_pen_tracker #(
      .BANK_W (BANK_W)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .bank    (bank),
      .neg     (ofs_neg),
      .evt     (evt),
      .stall_q (stall)
   );

   assign evt_vec = evt_to_vec(evt);

   for (genvar k = 0; k < NUM_PEN; k++) begin : g_cnt
      spad_pen_counter #(
         .CNT_W (CNT_W)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (evt_vec[k]),
         .count (cnt_arr[k])
      );
   end

   assign bank_cnt  = cnt_arr[PEN_BANK];
   assign sign_cnt  = cnt_arr[PEN_SIGN];
   assign stall_cnt = cnt_arr[PEN_STALL];

endmodule

// File: rtl/spad_penalty_mon_chk.sv
module spad_penalty_mon_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             acc_spad,
   input logic             stall,
   input logic [CNT_W-1:0] bank_cnt,
   input logic [CNT_W-1:0] sign_cnt,
   input logic [CNT_W-1:0] stall_cnt
);

   logic warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm <= 1'b0;
      else        warm <= 1'b1;
   end

   AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      stall |=> !stall); // R2

   AST_NONSPAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      (acc_valid && !acc_spad && !stall) |=> !stall); // R6

   AST_STALL_FROM_SPAD: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      stall |-> $past(acc_valid && acc_spad)); // R6

   AST_BUBBLE_COUNTED: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      stall |-> (stall_cnt == CNT_W'($past(stall_cnt) + CNT_W'(1)))); // R10

   AST_BUBBLE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      stall |-> ((bank_cnt != $past(bank_cnt)) || (sign_cnt != $past(sign_cnt)))); // R4

   AST_BANK_CNT_WITH_STALL: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      (bank_cnt != $past(bank_cnt)) |-> stall); // R2

   AST_SIGN_CNT_WITH_STALL: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      (sign_cnt != $past(sign_cnt)) |-> stall); // R3

   AST_HOLD_DURING_STALL: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      stall |=> ((bank_cnt == $past(bank_cnt)) && (sign_cnt == $past(sign_cnt))
                 && (stall_cnt == $past(stall_cnt)))); // R8

endmodule

bind spad_penalty_mon spad_penalty_mon_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_spad  (acc_spad),
   .stall     (stall),
   .bank_cnt  (bank_cnt),
   .sign_cnt  (sign_cnt),
   .stall_cnt (stall_cnt)
);

// File: tb/test_spad_penalty_mon.sv
`timescale 1ns/1ps
module test_spad_penalty_mon;

   logic        clk;
   logic        rst_n;
   logic        acc_valid;
   logic        acc_spad;
   logic [13:0] acc_addr;
   logic [15:0] acc_ofs;
   logic        stall;
   logic [15:0] bank_cnt;
   logic [15:0] sign_cnt;
   logic [15:0] stall_cnt;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // Reference model built from the requirements
   bit       m_have;
   bit [1:0] m_bank;
   bit       m_neg;
   int       e_bank, e_sign, e_stall;

   localparam logic [15:0] POS  = 16'sd8;
   localparam logic [15:0] NEG  = 16'hFFFC;
   localparam logic [15:0] ZERO = 16'd0;

   spad_penalty_mon i_spad_penalty_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_spad  (acc_spad),
      .acc_addr  (acc_addr),
      .acc_ofs   (acc_ofs),
      .stall     (stall),
      .bank_cnt  (bank_cnt),
      .sign_cnt  (sign_cnt),
      .stall_cnt (stall_cnt)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_cnts(input string req);
      check(int'(bank_cnt) == e_bank, req, "bank_cnt", int'(bank_cnt), e_bank);
      check(int'(sign_cnt) == e_sign, req, "sign_cnt", int'(sign_cnt), e_sign);
      check(int'(stall_cnt) == e_stall, req, "stall_cnt", int'(stall_cnt), e_stall);
   endtask

   function automatic logic [13:0] addr_of(input int bank, input int low);
      return 14'(bank * 4096 + low);
   endfunction

   // Predict the outcome of one accepted access and update the model
   function automatic bit predict(input bit spad, input logic [13:0] a,
                                  input logic [15:0] o);
      bit bc, sc;
      bc = 0; sc = 0;
      if (spad) begin
         if (m_have) begin
            bc = (a[13:12] != m_bank);
            sc = (o[15] != m_neg);
         end
         m_have = 1; m_bank = a[13:12]; m_neg = o[15];
      end
      if (bc) e_bank++;
      if (sc) e_sign++;
      if (bc || sc) e_stall++;
      return bc || sc;
   endfunction

   // One isolated access; starts and ends at a falling edge
   task automatic access(input bit spad, input logic [13:0] a,
                         input logic [15:0] o, input string req);
      bit exp_st;
      exp_st    = predict(spad, a, o);
      acc_valid = 1'b1; acc_spad = spad; acc_addr = a; acc_ofs = o;
      @(negedge clk);
      acc_valid = 1'b0; acc_spad = 1'b0;
      check(stall == exp_st, req, "stall", int'(stall), int'(exp_st));
      check_cnts(req);
      if (exp_st) begin
         @(negedge clk);
         check(stall == 1'b0, req, "stall one cycle", int'(stall), 0);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; acc_valid = 1'b0; acc_spad = 1'b0; acc_addr = '0; acc_ofs = '0;
      m_have = 0; m_bank = 0; m_neg = 0; e_bank = 0; e_sign = 0; e_stall = 0;
      repeat (3) @(negedge clk);
      check(stall == 1'b0, "R10", "stall in reset", int'(stall), 0);
      check_cnts("R10");
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_first();
      // R5: first access after reset, negative offset in bank 3
      access(1'b1, addr_of(3, 16), NEG, "R5");
   endtask

   task automatic t_bank_change();
      access(1'b1, addr_of(3, 32), NEG, "R2");
      access(1'b1, addr_of(1, 32), NEG, "R2");  // bank 3 -> 1
      access(1'b1, addr_of(1, 4095), NEG, "R1"); // top of bank 1, same bank
      access(1'b1, addr_of(2, 0), NEG, "R1");   // 4096 boundary -> bank 2
   endtask

   task automatic t_sign_change();
      access(1'b1, addr_of(2, 64), POS, "R3");  // same bank, sign flips
      access(1'b1, addr_of(2, 64), NEG, "R3");
   endtask

   task automatic t_zero();
      access(1'b1, addr_of(2, 8), ZERO, "R9");  // negative -> zero flips
      access(1'b1, addr_of(2, 8), POS, "R9");   // zero -> positive, no penalty
   endtask

   task automatic t_both();
      access(1'b1, addr_of(0, 8), NEG, "R4");   // bank and sign together
   endtask

   task automatic t_nonspad();
      access(1'b0, addr_of(3, 0), POS, "R6");
      access(1'b0, addr_of(1, 0), NEG, "R6");
      // history must still be bank 0 negative
      access(1'b1, addr_of(0, 100), NEG, "R6");
   endtask

   task automatic t_back_to_back();
      bit exp_st;
      for (int i = 0; i < 4; i++) begin
         exp_st    = predict(1'b1, addr_of(0, 16 * i), NEG);
         acc_valid = 1'b1; acc_spad = 1'b1; acc_addr = addr_of(0, 16 * i); acc_ofs = NEG;
         @(negedge clk);
         check(stall == 1'b0 && !exp_st, "R7", "stall back-to-back", int'(stall), 0);
      end
      acc_valid = 1'b0; acc_spad = 1'b0;
      check_cnts("R7");
   endtask

   task automatic t_ignore_in_stall();
      bit exp_st;
      exp_st    = predict(1'b1, addr_of(1, 0), POS); // penalised
      acc_valid = 1'b1; acc_spad = 1'b1; acc_addr = addr_of(1, 0); acc_ofs = POS;
      @(negedge clk);
      check(stall == exp_st, "R8", "stall", int'(stall), int'(exp_st));
      // offered during the bubble: must be dropped
      acc_addr = addr_of(3, 0); acc_ofs = NEG;
      @(negedge clk);
      acc_valid = 1'b0; acc_spad = 1'b0;
      check(stall == 1'b0, "R8", "stall after dropped access", int'(stall), 0);
      check_cnts("R8");
      // history is still bank 1 positive
      access(1'b1, addr_of(1, 12), POS, "R8");
   endtask

   initial begin
      t_reset();
      t_first();
      t_bank_change();
      t_sign_change();
      t_zero();
      t_both();
      t_nonspad();
      t_back_to_back();
      t_ignore_in_stall();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule